// File: doc/BRIEF.md
# Snooping Address Parity Generator and Checker

This block sits beside the address bus interface of a bus agent. While the agent owns the address bus and presents a valid address, it computes one odd-parity bit for each byte of the address. It drives those bits onto a parity output and raises an output enable with them.

While another master owns the bus, the block watches for snoop cycles. A snoop cycle is one where the transfer-start and global strobes are both high. In such a cycle it recomputes parity from the incoming address and compares it with the parity bits that arrive with it. A mismatch is reported only when parity checking is enabled. The report goes out as a machine-check request or as a checkstop request, chosen by a mode input.

Every reported mismatch also sets bits in a sticky per-lane error mask. Logic elsewhere can read that mask and clear it with a synchronous clear input. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block runs a few cycles after the pin rises.

Top module: `snoop_addr_parity`

## Requirements
- R1: Address bit 0 is the most significant bit and sits at `addr_i[0]`. Parity bit k covers address bits 8k to 8k+7, so `par_o[0]` covers `addr_i[0:7]` and `par_o[3]` covers `addr_i[24:31]`. Each parity bit makes the total count of ones in its byte plus the parity bit odd.
- R2: Out of reset, `par_oe_o` is 1 exactly when `own_bus_i` and `addr_vld_i` are both 1 in the same cycle. While it is 1, `par_o` carries the R1 parity of the present `addr_i`. While it is 0, `par_o` is 4'b0000.
- R3: While `rst_n` is low, `par_oe_o`, `par_o`, `mchk_req_o`, `ckstop_req_o` and `err_lanes_o` are all 0. This holds even when the agent owns the bus with a valid address.
- R4: A comparison takes place only in a cycle where `own_bus_i` is 0 and `snp_ts_i` and `snp_gbl_i` are both 1. Wrong parity in any other cycle produces no request and leaves `err_lanes_o` unchanged.
- R5: When `chk_en_i` is 0 in a snoop cycle, a parity mismatch raises no request and leaves `err_lanes_o` unchanged.
- R6: A reported mismatch raises `mchk_req_o` when `mce_i` is 1 and `ckstop_req_o` when `mce_i` is 0. Each is a one-cycle pulse in the cycle after the snoop cycle, and the two are never high together.
- R7: Snoop cycles on consecutive clocks are judged independently. A mismatch in each of two back-to-back cycles gives a request pulse in each of the two following cycles, and a clean cycle gives none.
- R8: `err_lanes_o` bit k becomes 1 in the cycle after a reported mismatch on lane k. It stays 1 until cleared, and it accumulates lanes across errors.
- R9: A cycle with `err_clr_i` high zeroes `err_lanes_o` from the next cycle on. The exception is lanes that fail a reported comparison in that same cycle: they are held in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 32 | Address bus, bit 0 most significant |
| own_bus_i | input | 1 | Local agent is the address bus master |
| addr_vld_i | input | 1 | Local agent presents a valid address |
| snp_ts_i | input | 1 | Transfer-start strobe seen on the bus |
| snp_gbl_i | input | 1 | Global (snoopable) strobe seen on the bus |
| par_i | input | 4 | Incoming address parity, bit k for byte k |
| chk_en_i | input | 1 | Address parity checking enable |
| mce_i | input | 1 | 1 selects machine-check reporting, 0 selects checkstop |
| err_clr_i | input | 1 | Synchronous clear of the sticky lane mask |
| par_o | output | 4 | Generated parity, bit k for byte k |
| par_oe_o | output | 1 | Parity output enable |
| mchk_req_o | output | 1 | Machine-check request pulse |
| ckstop_req_o | output | 1 | Checkstop request pulse |
| err_lanes_o | output | 4 | Sticky mask of failing byte lanes |

## Verification
The assertions check on every cycle that the enable follows bus ownership and a valid address. They also check that driven parity is odd per byte, and that the two requests are never high together. A request must follow a snoop cycle with checking enabled and the right mode, and with the local agent off the bus. The sticky mask must only gain bits unless a clear came before. Only the bench scenarios can show the remaining behaviour, and it checks each case against its own model. That covers the exact failing-lane mask, and the independence of back-to-back errors. It also covers a clear that collides with a new error, and the quiet outputs while reset is held.

// File: rtl/snoop_par_pkg.sv
package snoop_par_pkg;

  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    RPT_NONE   = 2'b00,
    RPT_MCHK   = 2'b01,
    RPT_CKSTOP = 2'b10
  } rpt_kind_e;

  function automatic rpt_kind_e pick_kind(input logic report, input logic mce);
    if (!report)  return RPT_NONE;
    else if (mce) return RPT_MCHK;
    else          return RPT_CKSTOP;
  endfunction

endpackage

// File: rtl/addr_par_gen.sv
module addr_par_gen #(
  parameter int unsigned ADDR_W = snoop_par_pkg::ADDR_W_DEF,
  parameter int unsigned LANE_W = snoop_par_pkg::LANE_W_DEF,
  localparam int unsigned NLANE = ADDR_W / LANE_W
) (
  input  logic [0:ADDR_W-1] addr,
  output logic [0:NLANE-1]  par
);

  // one odd-parity tree per byte lane, lane 0 at the most significant end
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [0:LANE_W-1] lane_bits;
    assign lane_bits = addr[k*LANE_W +: LANE_W];
    assign par[k]    = ~(^lane_bits);
  end

endmodule

// File: rtl/snoop_par_cmp.sv
module snoop_par_cmp #(
  parameter int unsigned NLANE = 4
) (
  input  logic             run,
  input  logic             own_bus,
  input  logic             ts,
  input  logic             gbl,
  input  logic             chk_en,
  input  logic [0:NLANE-1] calc_par,
  input  logic [0:NLANE-1] bus_par,
  output logic             report,
  output logic [0:NLANE-1] bad_lanes
);

  logic             qual;
  logic [0:NLANE-1] miss;

  always_comb begin
    qual      = run & ~own_bus & ts & gbl;
    miss      = calc_par ^ bus_par;
    report    = qual & chk_en & (|miss);
    bad_lanes = report ? miss : '0;
  end

endmodule

// File: rtl/par_err_route.sv
module par_err_route
  import snoop_par_pkg::*;
#(
  parameter int unsigned NLANE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             report,
  input  logic [0:NLANE-1] bad_lanes,
  input  logic             mce,
  input  logic             clr,
  output logic             mchk_req,
  output logic             ckstop_req,
  output logic [0:NLANE-1] sticky
);

  rpt_kind_e        kind_d, kind_q;
  logic [0:NLANE-1] sticky_d, sticky_q;

  always_comb begin
    kind_d   = pick_kind(report, mce);
    sticky_d = (clr ? '0 : sticky_q) | bad_lanes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= RPT_NONE;
      sticky_q <= '0;
    end else begin
      kind_q   <= kind_d;
      sticky_q <= sticky_d;
    end
  end

  assign mchk_req   = (kind_q == RPT_MCHK);
  assign ckstop_req = (kind_q == RPT_CKSTOP);
  assign sticky     = sticky_q;

endmodule

// File: rtl/snoop_addr_parity.sv
module snoop_addr_parity #(
  parameter int unsigned ADDR_W  = snoop_par_pkg::ADDR_W_DEF,
  parameter int unsigned LANE_W  = snoop_par_pkg::LANE_W_DEF,
  parameter int unsigned SYNC_ST = snoop_par_pkg::SYNC_DEF,
  localparam int unsigned NLANE  = ADDR_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [0:ADDR_W-1] addr_i,
  input  logic              own_bus_i,
  input  logic              addr_vld_i,
  input  logic              snp_ts_i,
  input  logic              snp_gbl_i,
  input  logic [0:NLANE-1]  par_i,
  input  logic              chk_en_i,
  input  logic              mce_i,
  input  logic              err_clr_i,
  output logic [0:NLANE-1]  par_o,
  output logic              par_oe_o,
  output logic              mchk_req_o,
  output logic              ckstop_req_o,
  output logic [0:NLANE-1]  err_lanes_o
);

  // reset: asserted at once, released after SYNC_ST clock edges
  logic [SYNC_ST-1:0] sync_q;
  logic               run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_ST-2:0], 1'b1};
  end
  assign run = sync_q[SYNC_ST-1];

  logic [0:NLANE-1] calc_par;
  logic             report;
  logic [0:NLANE-1] bad_lanes;

  addr_par_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_gen (
    .addr (addr_i),
    .par  (calc_par)
  );

  snoop_par_cmp #(.NLANE(NLANE)) u_cmp (
    .run       (run),
    .own_bus   (own_bus_i),
    .ts        (snp_ts_i),
    .gbl       (snp_gbl_i),
    .chk_en    (chk_en_i),
    .calc_par  (calc_par),
    .bus_par   (par_i),
    .report    (report),
    .bad_lanes (bad_lanes)
  );

  par_err_route #(.NLANE(NLANE)) u_route (
    .clk        (clk),
    .rst_n      (run),
    .report     (report),
    .bad_lanes  (bad_lanes),
    .mce        (mce_i),
    .clr        (err_clr_i),
    .mchk_req   (mchk_req_o),
    .ckstop_req (ckstop_req_o),
    .sticky     (err_lanes_o)
  );

  always_comb begin
    par_oe_o = run & own_bus_i & addr_vld_i;
    par_o    = par_oe_o ? calc_par : '0;
  end

endmodule

// File: rtl/snoop_addr_parity_sva.sv
module snoop_addr_parity_sva #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NLANE = ADDR_W / LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [0:ADDR_W-1] addr_i,
  input logic              own_bus_i,
  input logic              addr_vld_i,
  input logic              snp_ts_i,
  input logic              snp_gbl_i,
  input logic              chk_en_i,
  input logic              mce_i,
  input logic              err_clr_i,
  input logic [0:NLANE-1]  par_o,
  input logic              par_oe_o,
  input logic              mchk_req_o,
  input logic              ckstop_req_o,
  input logic [0:NLANE-1]  err_lanes_o
);

  a_r2_oe_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> (own_bus_i && addr_vld_i));

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !par_oe_o |-> (par_o == '0));

  for (genvar k = 0; k < NLANE; k++) begin : g_odd
    a_r1_odd_lane: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe_o |-> ($countones({addr_i[k*LANE_W +: LANE_W], par_o[k]}) % 2 == 1));
  end

  a_r6_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(mchk_req_o && ckstop_req_o));

  a_r6_mchk_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req_o |-> $past(mce_i));

  a_r6_ckstop_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ckstop_req_o |-> !$past(mce_i));

  a_r4_snoop_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mchk_req_o || ckstop_req_o) |->
      ($past(snp_ts_i) && $past(snp_gbl_i) && !$past(own_bus_i)));

  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mchk_req_o || ckstop_req_o) |-> $past(chk_en_i));

  a_r8_sticky_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(err_clr_i) |-> ((err_lanes_o & $past(err_lanes_o)) == $past(err_lanes_o)));

endmodule

bind snoop_addr_parity snoop_addr_parity_sva #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_i       (addr_i),
  .own_bus_i    (own_bus_i),
  .addr_vld_i   (addr_vld_i),
  .snp_ts_i     (snp_ts_i),
  .snp_gbl_i    (snp_gbl_i),
  .chk_en_i     (chk_en_i),
  .mce_i        (mce_i),
  .err_clr_i    (err_clr_i),
  .par_o        (par_o),
  .par_oe_o     (par_oe_o),
  .mchk_req_o   (mchk_req_o),
  .ckstop_req_o (ckstop_req_o),
  .err_lanes_o  (err_lanes_o)
);

// File: tb/tb_snoop_addr_parity.sv
module tb_snoop_addr_parity;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [0:31] addr;
  logic        own, vld, ts, gbl, chk_en, mce, clr;
  logic [0:3]  par_in;
  logic [0:3]  par_o, lanes_o;
  logic        oe_o, mchk_o, ckstop_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [0:3]  exp_lanes;

  always #10 clk = ~clk;

  snoop_addr_parity dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .own_bus_i(own), .addr_vld_i(vld),
    .snp_ts_i(ts), .snp_gbl_i(gbl), .par_i(par_in), .chk_en_i(chk_en), .mce_i(mce),
    .err_clr_i(clr), .par_o(par_o), .par_oe_o(oe_o), .mchk_req_o(mchk_o),
    .ckstop_req_o(ckstop_o), .err_lanes_o(lanes_o)
  );

  function automatic logic [0:3] ref_par(input logic [0:31] a);
    logic [0:3] p;
    for (int k = 0; k < 4; k++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(a[8*k+b]);
      p[k] = (ones % 2 == 0);
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle, check combinational then registered results
  task automatic step(input logic [0:31] a, input logic o, input logic v,
                      input logic t, input logic g, input logic [0:3] err_mask,
                      input logic en, input logic m, input logic c);
    logic [0:3] p, miss, exp_par;
    logic       rep, exp_oe;
    addr = a; own = o; vld = v; ts = t; gbl = g; chk_en = en; mce = m; clr = c;
    p = ref_par(a);
    par_in = p ^ err_mask;
    #2;
    exp_oe  = o & v;
    exp_par = exp_oe ? p : 4'b0000;
    check(oe_o == exp_oe, "R2 oe", {31'd0, oe_o}, {31'd0, exp_oe});
    check(par_o == exp_par, "R1/R2 par", {28'd0, par_o}, {28'd0, exp_par});
    miss = err_mask;
    rep  = !o && t && g && en && (miss != 0);
    exp_lanes = (c ? 4'b0000 : exp_lanes) | (rep ? miss : 4'b0000);
    @(posedge clk); #2;
    check(mchk_o == (rep && m), "R6/R7 mchk", {31'd0, mchk_o}, {31'd0, rep && m});
    check(ckstop_o == (rep && !m), "R6/R7 ckstop", {31'd0, ckstop_o}, {31'd0, rep && !m});
    check(lanes_o == exp_lanes, "R8/R9 lanes", {28'd0, lanes_o}, {28'd0, exp_lanes});
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_lanes = 4'b0000;
    rst_n = 1'b0; addr = 32'hA5A5_0F0F; own = 1'b1; vld = 1'b1; ts = 1'b1; gbl = 1'b1;
    par_in = 4'b1111; chk_en = 1'b1; mce = 1'b1; clr = 1'b0;
    repeat (3) @(negedge clk);
    // R3: quiet while reset is held, even as master with a valid address
    check(oe_o == 1'b0, "R3 oe", {31'd0, oe_o}, 32'd0);
    check(par_o == 4'b0000, "R3 par", {28'd0, par_o}, 32'd0);
    check(!mchk_o && !ckstop_o, "R3 req", {30'd0, mchk_o, ckstop_o}, 32'd0);
    check(lanes_o == 4'b0000, "R3 lanes", {28'd0, lanes_o}, 32'd0);
    rst_n = 1'b1;
    own = 1'b0; ts = 1'b0;
    repeat (4) @(negedge clk);

    // R1 lane mapping: one set bit in lane 0 only
    step(32'h8000_0000, 1, 1, 0, 0, 4'b0000, 1, 1, 0);
    check(par_o == 4'b0111, "R1 lane0 msb", {28'd0, par_o}, 32'h7);
    step(32'h0000_0001, 1, 1, 0, 0, 4'b0000, 1, 1, 0);
    step(32'hFFFF_FFFF, 1, 0, 0, 0, 4'b0000, 1, 1, 0);   // R2 no valid
    // R4: master with bad parity and strobes -> no check
    step(32'h1234_5678, 1, 1, 1, 1, 4'b1111, 1, 1, 0);
    // R4: ts without gbl -> no check
    step(32'h1234_5678, 0, 0, 1, 0, 4'b1000, 1, 1, 0);
    // R5: check disabled
    step(32'h1234_5678, 0, 0, 1, 1, 4'b0100, 0, 1, 0);
    // R6 mchk, then R7 back-to-back ckstop, then clean
    step(32'hDEAD_BEEF, 0, 0, 1, 1, 4'b0010, 1, 1, 0);
    step(32'hCAFE_F00D, 0, 0, 1, 1, 4'b0001, 1, 0, 0);
    step(32'hCAFE_F00D, 0, 0, 1, 1, 4'b0000, 1, 0, 0);
    check(lanes_o == 4'b0011, "R8 accumulate", {28'd0, lanes_o}, 32'h3);
    // R9: clear colliding with a new lane-0 error
    step(32'h0F0F_0F0F, 0, 0, 1, 1, 4'b1000, 1, 1, 1);
    check(lanes_o == 4'b1000, "R9 clear keeps new", {28'd0, lanes_o}, 32'h8);
    step(32'h0F0F_0F0F, 0, 0, 0, 0, 4'b0000, 1, 1, 1);

    for (int i = 0; i < 2000; i++) begin
      logic [0:3] em;
      em = ($urandom_range(0, 1) == 0) ? 4'b0000 : 4'($urandom);
      step($urandom, ($urandom_range(0, 1) == 0), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 7), em,
           ($urandom_range(0, 9) < 8), ($urandom_range(0, 1) == 0),
           ($urandom_range(0, 9) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule